// File: doc/BRIEF.md
# Quadrature Carrier NCO

This block is the local oscillator of a digital downconverter. It produces a sine and a cosine sample stream that a following mixer multiplies with incoming data. The tuning word is the modulo-2^32 sum of two parts. One is a center frequency that software writes in parallel. The other is an offset frequency shifted in one bit per clock on a serial data/sync pin pair. Both parts are committed to the active tuning register together, on a load strobe. A control input can drop the offset term from that sum.

The phase accumulator moves forward only on cycles that carry a qualified input sample. The output frequency is therefore set relative to the sample rate, with a resolution of the sample rate divided by 2^32. The tuning word is two's complement, so it covers minus to plus half the sample rate. Negative words pick the upper sideband and positive words pick the lower sideband.

A 10-bit phase offset, latched on its own strobe, is added to the top ten accumulator bits. The sum addresses a quarter-wave table that is computed at elaboration. A clear request zeroes the accumulator on the next qualified sample.

Top module: `carrier_nco`

## Requirements
- R1: While `rstN` is low, both outputs are 0, and the accumulator, active tuning word, phase offset and serial holding word are all zero. One clock after reset ends, the outputs show the phase-0 values.
- R2: A word on `cofData` arrives MSB first. The cycle in which `cofSync` is high carries the MSB. Each following cycle carries the next bit. One cycle after the 32nd bit is captured, the word moves into the holding register. A new `cofSync` in the middle of a word restarts the count.
- R3: On a cycle with `cfLoad` high, the active tuning word becomes (`cfWord` + holding word) mod 2^32, using the holding word as it stood before that edge. With `cfLoad` low, the tuning word does not change.
- R4: When `offZero` is 1 at a `cfLoad`, the offset term is replaced by 0.
- R5: The accumulator adds the tuning word, mod 2^32, only on cycles with `sampleEn` high. On every other cycle it holds its value.
- R6: The lookup phase is (accumulator bits 31:22 + phase offset) mod 1024. The phase offset takes `phaseOffset` only on cycles with `phaseLoad` high.
- R7: An `accClear` pulse zeroes the accumulator on the first `sampleEn` cycle at or after the pulse. If `accClear` and `sampleEn` are high in the same cycle, the zeroing happens in that cycle.
- R8: For lookup phase p, `sinOut` = round(131071·sin(2π(p+0.5)/1024)) and `cosOut` = round(131071·cos(2π(p+0.5)/1024)), each within ±2 LSB, as signed 18-bit values. The outputs are registered one clock after the accumulator and phase offset they reflect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleEn | input | 1 | Qualifies an input sample; steps the accumulator |
| cfWord | input | 32 | Center frequency word |
| cfLoad | input | 1 | Commits center + offset to the tuning register |
| offZero | input | 1 | Drops the offset term at commit |
| cofData | input | 1 | Serial offset data, MSB first |
| cofSync | input | 1 | Marks the MSB cycle of a serial word |
| phaseOffset | input | 10 | Phase offset value |
| phaseLoad | input | 1 | Latches the phase offset |
| accClear | input | 1 | Requests zeroing of the accumulator |
| sinOut | output | 18 | Signed sine sample |
| cosOut | output | 18 | Signed cosine sample |

## Verification
Every result appears on the ports one clock after the edge that changes the state behind it. A sample step, a tuning commit or a phase-offset latch at edge k moves the outputs at edge k+1, because the lookup register follows the accumulator. A serial word reaches the holding register two edges after its last bit is presented, and it only reaches the outputs through a later commit and sample step. The bench keeps a behavioural model that applies the same edge semantics. It compares both outputs against that model at every falling edge, which puts each comparison half a period after the edge that produced the value.

// File: rtl/nco_pkg.sv
package nco_pkg;

  typedef struct packed {
    logic step;      // qualified sample: advance accumulator
    logic clr;       // zero accumulator on this step
    logic freqUpd;   // commit tuning word
    logic phsUpd;    // latch phase offset
    logic holdLoad;  // move serial shifter into holding register
  } nco_strobe_t;

  // Quarter-wave entry k of a table addressed by idxBits of full-circle phase.
  // Angle = (2k+1)*pi / 2^idxBits, Taylor series in Q30 fixed point.
  function automatic longint quarterSine(input int k, input int idxBits, input int outBits);
    longint piQ30;
    longint x;
    longint x2;
    longint term;
    longint s;
    longint amp;
    piQ30 = 64'sd3373259426;
    x = ((2 * longint'(k) + 1) * piQ30) >>> idxBits;
    x2 = (x * x) >>> 30;
    term = x;
    s = x;
    for (int n = 1; n <= 5; n++) begin
      term = (term * x2) >>> 30;
      term = term / longint'((2 * n) * (2 * n + 1));
      if (n % 2 == 1) s = s - term;
      else s = s + term;
    end
    amp = (longint'(1) <<< (outBits - 1)) - 1;
    return (s * amp + (longint'(1) <<< 29)) >>> 30;
  endfunction

endpackage

// File: rtl/nco_ctrl.sv
module nco_ctrl #(
  parameter int ACC_W = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sampleEn,
  input  logic                 cfLoad,
  input  logic                 phaseLoad,
  input  logic                 accClear,
  input  logic                 cofData,
  input  logic                 cofSync,
  output nco_pkg::nco_strobe_t stb,
  output logic [ACC_W-1:0]     shiftWord
);
  localparam int CNT_W = $clog2(ACC_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(ACC_W);

  logic [CNT_W-1:0] bitCnt;
  logic             clrPend;
  logic             clrNow;

  assign clrNow       = accClear | clrPend;
  assign stb.step     = sampleEn;
  assign stb.clr      = sampleEn & clrNow;
  assign stb.freqUpd  = cfLoad;
  assign stb.phsUpd   = phaseLoad;
  assign stb.holdLoad = (bitCnt == FULL);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt    <= '0;
      shiftWord <= '0;
    end else if (cofSync) begin
      shiftWord <= {shiftWord[ACC_W-2:0], cofData};
      bitCnt    <= CNT_W'(1);
    end else if (bitCnt != '0 && bitCnt < FULL) begin
      shiftWord <= {shiftWord[ACC_W-2:0], cofData};
      bitCnt    <= bitCnt + CNT_W'(1);
    end else begin
      bitCnt    <= '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   clrPend <= 1'b0;
    else if (sampleEn && clrNow) clrPend <= 1'b0;
    else if (accClear)           clrPend <= 1'b1;
  end

  // R2: a finished word is transferred exactly once
  p_transfer_once_r2: assert property (@(posedge clk) disable iff (!rstN)
    stb.holdLoad |=> !stb.holdLoad);

  // R7: a clear request not served on this cycle is held for the next step
  p_clear_kept_r7: assert property (@(posedge clk) disable iff (!rstN)
    (accClear && !sampleEn) |=> clrNow);

endmodule

// File: rtl/nco_datapath.sv
module nco_datapath #(
  parameter int ACC_W  = 32,
  parameter int POFF_W = 10,
  parameter int OUT_W  = 18
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  nco_pkg::nco_strobe_t     stb,
  input  logic [ACC_W-1:0]         cfWord,
  input  logic [ACC_W-1:0]         shiftWord,
  input  logic                     offZero,
  input  logic [POFF_W-1:0]        phaseOffset,
  output logic signed [OUT_W-1:0]  sinOut,
  output logic signed [OUT_W-1:0]  cosOut
);
  localparam int QIDX_W = POFF_W - 2;
  localparam int QDEPTH = 1 << QIDX_W;
  localparam int TAB_W  = OUT_W - 1;
  localparam logic [POFF_W-1:0] QUARTER = POFF_W'(QDEPTH);

  logic [ACC_W-1:0]  acc;
  logic [ACC_W-1:0]  freqReg;
  logic [ACC_W-1:0]  offHold;
  logic [POFF_W-1:0] phOff;
  logic [POFF_W-1:0] sinPh;
  logic [POFF_W-1:0] cosPh;
  logic [TAB_W-1:0]  quarterTab [QDEPTH];

  for (genvar g = 0; g < QDEPTH; g++) begin : g_tab
    assign quarterTab[g] = TAB_W'(nco_pkg::quarterSine(g, POFF_W, OUT_W));
  end

  function automatic logic signed [OUT_W-1:0] waveAt(input logic [POFF_W-1:0] ph);
    logic [QIDX_W-1:0] idx;
    logic [TAB_W-1:0]  mag;
    idx = ph[POFF_W-2] ? ~ph[QIDX_W-1:0] : ph[QIDX_W-1:0];
    mag = quarterTab[idx];
    return ph[POFF_W-1] ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
  endfunction

  assign sinPh = acc[ACC_W-1 -: POFF_W] + phOff;
  assign cosPh = sinPh + QUARTER;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      offHold <= '0;
      freqReg <= '0;
      phOff   <= '0;
    end else begin
      if (stb.holdLoad) offHold <= shiftWord;
      if (stb.freqUpd)  freqReg <= cfWord + (offZero ? '0 : offHold);
      if (stb.phsUpd)   phOff   <= phaseOffset;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          acc <= '0;
    else if (stb.clr)   acc <= '0;
    else if (stb.step)  acc <= acc + freqReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sinOut <= '0;
      cosOut <= '0;
    end else begin
      sinOut <= waveAt(sinPh);
      cosOut <= waveAt(cosPh);
    end
  end

  // R5: no sample, no phase movement
  p_hold_no_sample_r5: assert property (@(posedge clk) disable iff (!rstN)
    !stb.step |=> $stable(acc));

  // R7: a served clear leaves the accumulator at zero
  p_clear_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    stb.clr |=> (acc == '0));

  // R3: tuning word only changes on commit
  p_freq_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !stb.freqUpd |=> $stable(freqReg));

  // R6: phase offset only changes on its strobe
  p_phase_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !stb.phsUpd |=> $stable(phOff));

  // R2: holding word only changes on a transfer
  p_hold_stable_r2: assert property (@(posedge clk) disable iff (!rstN)
    !stb.holdLoad |=> $stable(offHold));

endmodule

// File: rtl/carrier_nco.sv
module carrier_nco #(
  parameter int ACC_W  = 32,
  parameter int POFF_W = 10,
  parameter int OUT_W  = 18
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    sampleEn,
  input  logic [ACC_W-1:0]        cfWord,
  input  logic                    cfLoad,
  input  logic                    offZero,
  input  logic                    cofData,
  input  logic                    cofSync,
  input  logic [POFF_W-1:0]       phaseOffset,
  input  logic                    phaseLoad,
  input  logic                    accClear,
  output logic signed [OUT_W-1:0] sinOut,
  output logic signed [OUT_W-1:0] cosOut
);
  nco_pkg::nco_strobe_t stb;
  logic [ACC_W-1:0]     shiftWord;

  nco_ctrl #(.ACC_W(ACC_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .sampleEn  (sampleEn),
    .cfLoad    (cfLoad),
    .phaseLoad (phaseLoad),
    .accClear  (accClear),
    .cofData   (cofData),
    .cofSync   (cofSync),
    .stb       (stb),
    .shiftWord (shiftWord)
  );

  nco_datapath #(.ACC_W(ACC_W), .POFF_W(POFF_W), .OUT_W(OUT_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .cfWord      (cfWord),
    .shiftWord   (shiftWord),
    .offZero     (offZero),
    .phaseOffset (phaseOffset),
    .sinOut      (sinOut),
    .cosOut      (cosOut)
  );

endmodule

// File: tb/carrier_nco_bench.sv
`timescale 1ns/1ps
module carrier_nco_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sampleEn = 1'b0;
  logic [31:0] cfWord = '0;
  logic        cfLoad = 1'b0;
  logic        offZero = 1'b0;
  logic        cofData = 1'b0;
  logic        cofSync = 1'b0;
  logic [9:0]  phaseOffset = '0;
  logic        phaseLoad = 1'b0;
  logic        accClear = 1'b0;
  logic signed [17:0] sinOut;
  logic signed [17:0] cosOut;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  string curReq = "R1";

  always #5 clk = ~clk;

  carrier_nco u_carrier_nco (
    .clk(clk), .rstN(rstN), .sampleEn(sampleEn), .cfWord(cfWord), .cfLoad(cfLoad),
    .offZero(offZero), .cofData(cofData), .cofSync(cofSync), .phaseOffset(phaseOffset),
    .phaseLoad(phaseLoad), .accClear(accClear), .sinOut(sinOut), .cosOut(cosOut)
  );

  // ---- behavioural reference ----
  longint mAcc, mFreq, mHold, mSreg, mPh;
  int     mCnt;
  bit     mPend;
  int     mSin, mCos;
  localparam longint MASK = 64'hFFFF_FFFF;

  function automatic int refWave(input int p, input bit isCos);
    real ang;
    real v;
    ang = 2.0 * 3.14159265358979 * (real'(p) + 0.5) / 1024.0;
    v = 131071.0 * (isCos ? $cos(ang) : $sin(ang));
    return int'($floor(v + 0.5));
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mAcc = 0; mFreq = 0; mHold = 0; mSreg = 0; mPh = 0;
      mCnt = 0; mPend = 0; mSin = 0; mCos = 0;
    end else begin
      int p;
      longint nAcc, nFreq, nHold, nSreg, nPh;
      int nCnt;
      bit nPend;
      p = int'(((mAcc >> 22) + mPh) % 1024);
      nAcc = mAcc; nFreq = mFreq; nHold = mHold; nSreg = mSreg; nPh = mPh;
      nCnt = mCnt; nPend = mPend;
      if (cfLoad) nFreq = (longint'(cfWord) + (offZero ? 0 : mHold)) & MASK;
      if (phaseLoad) nPh = longint'(phaseOffset);
      if (sampleEn) begin
        if (accClear || mPend) begin nAcc = 0; nPend = 0; end
        else nAcc = (mAcc + mFreq) & MASK;
      end else if (accClear) nPend = 1;
      if (mCnt == 32) nHold = mSreg;
      if (cofSync) begin
        nSreg = ((mSreg << 1) | longint'(cofData)) & MASK; nCnt = 1;
      end else if (mCnt > 0 && mCnt < 32) begin
        nSreg = ((mSreg << 1) | longint'(cofData)) & MASK; nCnt = mCnt + 1;
      end else nCnt = 0;
      mSin = refWave(p, 0);
      mCos = refWave(p, 1);
      mAcc = nAcc; mFreq = nFreq; mHold = nHold; mSreg = nSreg; mPh = nPh;
      mCnt = nCnt; mPend = nPend;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp, input int tol);
    int d;
    checks++;
    d = act - exp;
    if (d < 0) d = -d;
    if (d > tol) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // every-cycle comparison, half a period after the producing edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      chk(curReq, "sinOut", int'(sinOut), mSin, 2);
      chk(curReq, "cosOut", int'(cosOut), mCos, 2);
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic steps(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sampleEn = 1'b1;
      @(negedge clk); sampleEn = 1'b0;
      if (gap > 0) idle(gap);
    end
  endtask

  task automatic sendSerial(input logic [31:0] w, input int nBits);
    for (int i = 0; i < nBits; i++) begin
      @(negedge clk);
      cofSync = (i == 0);
      cofData = w[31 - i];
    end
    @(negedge clk); cofSync = 1'b0; cofData = 1'b0;
  endtask

  task automatic commit(input logic [31:0] cf, input bit z);
    @(negedge clk); cfWord = cf; offZero = z; cfLoad = 1'b1;
    @(negedge clk); cfLoad = 1'b0; offZero = 1'b0;
  endtask

  initial begin
    // R1: reset state
    idle(3);
    chk("R1", "sinOut in reset", int'(sinOut), 0, 0);
    chk("R1", "cosOut in reset", int'(cosOut), 0, 0);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    chk("R1", "sinOut phase0", int'(sinOut), refWave(0, 0), 2);
    chk("R1", "cosOut phase0", int'(cosOut), refWave(0, 1), 2);

    // R5: enabled steps with a zero tuning word leave the phase at 0
    curReq = "R5";
    steps(4, 1);
    chk("R5", "sinOut zero word", int'(sinOut), refWave(0, 0), 2);

    // R3: commit a center word, step with irregular gaps
    curReq = "R3";
    commit(32'h0100_0000, 1'b0);
    steps(6, 0);
    steps(5, 3);
    idle(2);
    chk("R3", "sinOut after 11 steps", int'(sinOut), refWave(44, 0), 2);
    cfWord = 32'h7777_0000; idle(4);   // no strobe: no change

    // R2: serial offset, with a restarted word first
    curReq = "R2";
    sendSerial(32'hFFFF_FFFF, 10);
    sendSerial(32'h0040_0000, 32);
    idle(2);
    commit(32'h0100_0000, 1'b0);
    steps(8, 1);
    idle(1);
    chk("R2", "sinOut center+offset", int'(sinOut), refWave(44 + 8 * 5, 0), 2);

    // R4: offset zeroed at commit
    curReq = "R4";
    commit(32'h0100_0000, 1'b1);
    steps(6, 0);

    // R6: phase offset latched on strobe
    curReq = "R6";
    @(negedge clk); phaseOffset = 10'd256; phaseLoad = 1'b1;
    @(negedge clk); phaseLoad = 1'b0; phaseOffset = 10'd900;
    idle(3);
    steps(3, 2);
    @(negedge clk); phaseOffset = 10'd1000; phaseLoad = 1'b1;
    @(negedge clk); phaseLoad = 1'b0;
    idle(2);

    // R7: clear pending until the next sample, then a same-cycle clear
    curReq = "R7";
    @(negedge clk); accClear = 1'b1;
    @(negedge clk); accClear = 1'b0;
    idle(4);
    steps(1, 1);
    @(negedge clk); phaseOffset = 10'd0; phaseLoad = 1'b1;
    @(negedge clk); phaseLoad = 1'b0;
    idle(1);
    chk("R7", "sinOut after clear", int'(sinOut), refWave(0, 0), 2);
    steps(5, 0);
    @(negedge clk); accClear = 1'b1; sampleEn = 1'b1;
    @(negedge clk); accClear = 1'b0; sampleEn = 1'b0;
    idle(1);
    chk("R7", "cosOut same-cycle clear", int'(cosOut), refWave(0, 1), 2);

    // R8: negative word (upper sideband) and a fast sweep across all quadrants
    curReq = "R8";
    commit(32'hFE00_0000, 1'b0);
    steps(40, 0);
    commit(32'h0370_0000, 1'b1);
    @(negedge clk); sampleEn = 1'b1;
    idle(700);
    @(negedge clk); sampleEn = 1'b0;
    commit(32'h8000_0000, 1'b1);
    steps(6, 0);
    idle(3);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(100000 * 10);
    if (!finished) begin
      finished = 1;
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule